// File: doc/BRIEF.md
# Byte-Lane Steering Access Splitter

This block sits between the load/store port of a processor core and a 16-bit little-endian memory bus built from two byte banks: an even bank on data lanes 7:0 and an odd bank on data lanes 15:8. The core asks for a byte or a word at any byte address. The block chooses the bank enables, puts each byte on the lane of its bank, and completes the request with as many bus cycles as the alignment needs. A word at an even address takes one bus cycle. A word at an odd address takes two single-byte cycles. Neither case raises a fault. Read results come back to the core as a right-justified 16-bit value.

Bank selection uses an active-low high-byte enable together with address bit 0. Bit 0 low enables the even bank, and the high-byte enable active enables the odd bank. The pair {bus_bhe_n, bus_addr[0]} is 00 for a full word, 01 for the odd byte only and 10 for the even byte only. The value 11 is never driven. Instruction fetches always go out as aligned word reads. The core holds `req_valid` until `core_done` pulses. The bus side holds `bus_req` and everything it drives until `bus_ack` is seen, so any number of wait cycles can be inserted.

Control is a four-state machine. `ST_IDLE` accepts a request and moves to `ST_BUS_A`. `ST_BUS_A` runs the first or only bus cycle. On `bus_ack` it moves to `ST_BUS_B` if the word is misaligned, and to `ST_RESP` otherwise. `ST_BUS_B` runs the second byte cycle and moves to `ST_RESP` on `bus_ack`. `ST_RESP` pulses `core_done` for one cycle and returns to `ST_IDLE`. Reset forces `ST_IDLE` from any state.

Top module: `lane_split_bridge`

## Requirements
- R1: A word request at an even address makes exactly one bus cycle at that address with {bus_bhe_n, bus_addr[0]} = 00. Bits 7:0 of write data go on lanes 7:0 and bits 15:8 on lanes 15:8. A read returns {lanes 15:8, lanes 7:0}.
- R2: A byte request at an even address makes one bus cycle with {bus_bhe_n, bus_addr[0]} = 10. The byte travels on lanes 7:0. A read returns it zero-extended in bits 7:0.
- R3: A byte request at an odd address makes one bus cycle with {bus_bhe_n, bus_addr[0]} = 01. The byte travels on lanes 15:8. A read returns it zero-extended in bits 7:0. While bus_req is high, {bus_bhe_n, bus_addr[0]} is never 11.
- R4: A word request at an odd address N makes exactly two bus cycles and no fault. The first is at N with code 01 and carries the low byte on lanes 15:8. The second is at N+1 with code 10 and carries the high byte on lanes 7:0.
- R5: For a misaligned word read, the byte from the first cycle becomes result bits 7:0 and the byte from the second cycle becomes bits 15:8. core_done is raised only after the second cycle is acknowledged.
- R6: In a single-byte write cycle, the lane whose bank is not enabled carries a copy of the byte being written. Memory outside the addressed bytes is left unchanged.
- R7: A request with req_fetch high is performed as one aligned word read at req_addr with bit 0 cleared. This holds whatever req_write, req_word or req_addr[0] say.
- R8: A misaligned word at the top address FFFFFh places its second cycle at 00000h.
- R9: While bus_req is high and bus_ack is low, bus_req, bus_addr, bus_bhe_n, bus_we and bus_wdata hold their values.
- R10: After reset, and whenever rst_n is low, bus_req and core_done are low. core_done is a one-cycle pulse per request, raised one cycle after the final bus_ack, and bus_req is low while core_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present; held until core_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit operand, 0 = byte |
| req_fetch | input | 1 | Instruction fetch (forced aligned word read) |
| req_addr | input | 20 | Byte address of the operand |
| req_wdata | input | 16 | Store data, byte in bits 7:0 for byte stores |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 16 | Right-justified load result, valid with core_done |
| bus_req | output | 1 | Bus cycle request |
| bus_addr | output | 20 | Bus byte address; bit 0 also gates the even bank |
| bus_bhe_n | output | 1 | Odd-bank enable, active low |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both banks |
| bus_ack | input | 1 | Bus cycle completion |

## Verification
The bench targets misaligned words. If the split were missing, a wrong number of cycles would appear. If the second address or its enable code were wrong, the even bank would be hit at the wrong place. If the merge order were swapped, the two result bytes would come back exchanged. The address FFFFFh is driven to confirm the second cycle wraps to zero and does not run off the top. Byte stores are checked on both lanes, because a design that leaves the idle lane at zero, or enables both banks, would corrupt the neighbouring byte in the memory model. Fetches at odd addresses with the write bit set, wait states on the bus, and a reset in the middle of a cycle are also driven. These catch a fetch that is not forced aligned, bus signals that move before the acknowledge, and a done pulse that is early or stretched.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    // Encoded as {bus_bhe_n, address bit 0}
    typedef enum logic [1:0] {
        SEL_WORD = 2'b00,
        SEL_ODD  = 2'b01,
        SEL_EVEN = 2'b10
    } lane_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUS_A = 2'd1,
        ST_BUS_B = 2'd2,
        ST_RESP  = 2'd3
    } lsb_state_e;

endpackage

// File: rtl/lsb_req_decode.sv
module lsb_req_decode
    import lsb_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_write,
    output logic              dec_split,
    output logic [ADDR_W-1:0] dec_addr_a,
    output logic [ADDR_W-1:0] dec_addr_b,
    output lane_sel_e         dec_sel_a
);

    logic              eff_word;
    logic [ADDR_W-1:0] base;

    always_comb begin
        // fetches are always aligned word reads
        eff_word   = req_word | req_fetch;
        dec_write  = req_write & ~req_fetch;
        base       = req_fetch ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
        dec_split  = eff_word & base[0];
        dec_addr_a = base;
        dec_addr_b = base + ADDR_W'(1);
        if (eff_word && !base[0]) begin
            dec_sel_a = SEL_WORD;
        end else if (base[0]) begin
            dec_sel_a = SEL_ODD;
        end else begin
            dec_sel_a = SEL_EVEN;
        end
    end

endmodule

// File: rtl/lsb_lane_steer.sv
module lsb_lane_steer
    import lsb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  lane_sel_e           sel,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic [2*BYTE_W-1:0] word_in,
    output logic [2*BYTE_W-1:0] lanes
);

    localparam int LANES = 2;

    // A single byte is copied onto both lanes; the enables pick the bank.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g*BYTE_W +: BYTE_W] =
            (sel == SEL_WORD) ? word_in[g*BYTE_W +: BYTE_W] : byte_in;
    end

endmodule

// File: rtl/lsb_read_merge.sv
module lsb_read_merge
    import lsb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                cap,
    input  lane_sel_e           sel,
    input  logic                slot_hi,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    output logic [2*BYTE_W-1:0] result
);

    logic [BYTE_W-1:0] pick;

    always_comb begin
        pick = (sel == SEL_ODD) ? bus_rdata[2*BYTE_W-1:BYTE_W]
                                : bus_rdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (clear) begin
            result <= '0;
        end else if (cap) begin
            if (sel == SEL_WORD) begin
                result <= bus_rdata;
            end else if (slot_hi) begin
                result[2*BYTE_W-1:BYTE_W] <= pick;
            end else begin
                result[BYTE_W-1:0] <= pick;
            end
        end
    end

endmodule

// File: rtl/lane_split_bridge.sv
module lane_split_bridge
    import lsb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic                req_fetch,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                core_done,
    output logic [2*BYTE_W-1:0] core_rdata,
    output logic                bus_req,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_bhe_n,
    output logic                bus_we,
    output logic [2*BYTE_W-1:0] bus_wdata,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    input  logic                bus_ack
);

    localparam int DATA_W = 2 * BYTE_W;

    lsb_state_e        state_q, state_d;
    logic              write_q, split_q;
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    lane_sel_e         sel_a_q;
    logic [DATA_W-1:0] wdata_q;

    logic              dec_write, dec_split;
    logic [ADDR_W-1:0] dec_addr_a, dec_addr_b;
    lane_sel_e         dec_sel_a;

    lane_sel_e         cur_sel;
    logic [BYTE_W-1:0] cur_byte;
    logic              accept, capture, in_b;

    lsb_req_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_write (req_write),
        .req_word  (req_word),
        .req_fetch (req_fetch),
        .req_addr  (req_addr),
        .dec_write (dec_write),
        .dec_split (dec_split),
        .dec_addr_a(dec_addr_a),
        .dec_addr_b(dec_addr_b),
        .dec_sel_a (dec_sel_a)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_BUS_A;
            ST_BUS_A: if (bus_ack)   state_d = split_q ? ST_BUS_B : ST_RESP;
            ST_BUS_B: if (bus_ack)   state_d = ST_RESP;
            ST_RESP:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            split_q  <= 1'b0;
            addr_a_q <= '0;
            addr_b_q <= '0;
            sel_a_q  <= SEL_EVEN;
            wdata_q  <= '0;
        end else if (accept) begin
            write_q  <= dec_write;
            split_q  <= dec_split;
            addr_a_q <= dec_addr_a;
            addr_b_q <= dec_addr_b;
            sel_a_q  <= dec_sel_a;
            wdata_q  <= req_wdata;
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        core_done = 1'b0;
        in_b      = 1'b0;
        cur_sel   = sel_a_q;
        cur_byte  = wdata_q[BYTE_W-1:0];
        bus_addr  = addr_a_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUS_A: bus_req = 1'b1;
            ST_BUS_B: begin
                bus_req  = 1'b1;
                in_b     = 1'b1;
                cur_sel  = SEL_EVEN;
                cur_byte = wdata_q[DATA_W-1:BYTE_W];
                bus_addr = addr_b_q;
            end
            ST_RESP: core_done = 1'b1;
            default: ;
        endcase
        bus_bhe_n = cur_sel[1];
        bus_we    = bus_req & write_q;
        accept    = (state_q == ST_IDLE) & req_valid;
        capture   = bus_req & bus_ack & ~write_q;
    end

    lsb_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
        .sel    (cur_sel),
        .byte_in(cur_byte),
        .word_in(wdata_q),
        .lanes  (bus_wdata)
    );

    lsb_read_merge #(.BYTE_W(BYTE_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .cap      (capture),
        .sel      (cur_sel),
        .slot_hi  (in_b),
        .bus_rdata(bus_rdata),
        .result   (core_rdata)
    );

endmodule

// File: rtl/lsb_checks.sv
module lsb_checks #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                core_done,
    input logic                bus_req,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_bhe_n,
    input logic                bus_we,
    input logic [2*BYTE_W-1:0] bus_wdata,
    input logic                bus_ack
);

    // R3: no cycle with both banks disabled
    a_r3_no_dead_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !(bus_bhe_n && bus_addr[0]));

    // R4, R8: an acknowledged odd cycle is followed by idle or the next even byte
    a_r4_split_next_even: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_addr[0]) |=>
        (!bus_req || ((bus_addr - $past(bus_addr)) == ADDR_W'(1)
                      && !bus_addr[0] && bus_bhe_n)));

    // R6: a byte write carries the byte on both lanes
    a_r6_lane_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && (bus_bhe_n || bus_addr[0])) |->
        (bus_wdata[2*BYTE_W-1:BYTE_W] == bus_wdata[BYTE_W-1:0]));

    // R9: bus cycle held until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=>
        (bus_req && $stable(bus_addr) && $stable(bus_bhe_n)
         && $stable(bus_we) && $stable(bus_wdata)));

    // R10: done is a single pulse with the bus idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    a_r10_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> !bus_req);

endmodule

bind lane_split_bridge lsb_checks #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_done(core_done),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_bhe_n(bus_bhe_n),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack)
);

// File: tb/lane_split_bridge_bench.sv
`timescale 1ns/1ps
module lane_split_bridge_bench;

    typedef struct packed {
        logic        wr;
        logic        wd;
        logic        fe;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [1:0]  ncyc;
        logic [1:0]  sel0;
        logic [3:0]  waits;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 20'h00010, 16'h0000, 2'd1, 2'b00, 4'd0},
        '{1'b0, 1'b1, 1'b0, 20'h00011, 16'h0000, 2'd2, 2'b01, 4'd2},
        '{1'b0, 1'b0, 1'b0, 20'h00020, 16'h0000, 2'd1, 2'b10, 4'd1},
        '{1'b0, 1'b0, 1'b0, 20'h00021, 16'h0000, 2'd1, 2'b01, 4'd0},
        '{1'b1, 1'b1, 1'b0, 20'h00008, 16'hA1B2, 2'd1, 2'b00, 4'd3},
        '{1'b1, 1'b1, 1'b0, 20'h0000B, 16'hC3D4, 2'd2, 2'b01, 4'd1},
        '{1'b1, 1'b0, 1'b0, 20'h00030, 16'h995E, 2'd1, 2'b10, 4'd0},
        '{1'b1, 1'b0, 1'b0, 20'h00031, 16'h886F, 2'd1, 2'b01, 4'd2},
        '{1'b0, 1'b0, 1'b1, 20'h00015, 16'h0000, 2'd1, 2'b00, 4'd0},
        '{1'b1, 1'b0, 1'b1, 20'h00019, 16'h1234, 2'd1, 2'b00, 4'd1},
        '{1'b0, 1'b1, 1'b0, 20'hFFFFF, 16'h0000, 2'd2, 2'b01, 4'd0},
        '{1'b1, 1'b1, 1'b0, 20'hFFFFF, 16'h7788, 2'd2, 2'b01, 4'd4},
        '{1'b0, 1'b1, 1'b0, 20'h0000B, 16'h0000, 2'd2, 2'b01, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        core_done;
    logic [15:0] core_rdata;
    logic        bus_req, bus_bhe_n, bus_we;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #4 clk = ~clk;

    lane_split_bridge u_lane_split_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
        .core_done(core_done), .core_rdata(core_rdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
        .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] mem [64];
    logic [7:0] shadow [64];

    // bus log
    int          nlog = 0;
    logic [19:0] log_addr [4];
    logic [1:0]  log_sel  [4];
    logic [15:0] log_wdata[4];
    logic        log_we   [4];
    int          wait_cfg = 0, wcnt = 0, hold_bad = 0;
    bit          holding = 0;
    logic [19:0] snap_addr;
    logic [15:0] snap_wdata;
    logic        snap_bhe, snap_we;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus slave with programmable wait cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; wcnt = 0; holding = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0; wcnt = 0; holding = 0;
        end else if (bus_req) begin
            if (holding) begin
                if (bus_addr !== snap_addr || bus_wdata !== snap_wdata ||
                    bus_bhe_n !== snap_bhe || bus_we !== snap_we) hold_bad++;
            end else begin
                holding = 1; snap_addr = bus_addr; snap_wdata = bus_wdata;
                snap_bhe = bus_bhe_n; snap_we = bus_we;
            end
            if (wcnt >= wait_cfg) begin
                bus_ack = 1'b1;
                if (nlog < 4) begin
                    log_addr[nlog]  = bus_addr;
                    log_sel[nlog]   = {bus_bhe_n, bus_addr[0]};
                    log_wdata[nlog] = bus_wdata;
                    log_we[nlog]    = bus_we;
                end
                nlog++;
                if (bus_we) begin
                    if (!bus_addr[0]) mem[{bus_addr[5:1], 1'b0}] = bus_wdata[7:0];
                    if (!bus_bhe_n)   mem[{bus_addr[5:1], 1'b1}] = bus_wdata[15:8];
                end
                bus_rdata = {mem[{bus_addr[5:1], 1'b1}], mem[{bus_addr[5:1], 1'b0}]};
            end else begin
                wcnt++;
            end
        end
    end

    task automatic run_req(input vec_t v, output logic [15:0] rd);
        int guard = 0;
        @(negedge clk);
        nlog = 0;
        wait_cfg = int'(v.waits);
        req_write = v.wr; req_word = v.wd; req_fetch = v.fe;
        req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
        do begin
            @(negedge clk);
            guard++;
        end while (!core_done && guard < 100);
        rd = core_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(core_done == 1'b0, "R10 done single pulse", 32'(core_done), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, exp_rd;
        logic [19:0] ea, eb;
        bit          eword, ewrite;
        bit          mem_ok;
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'(i * 29 + 3);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0 && core_done == 1'b0, "R10 reset state",
            {bus_req, core_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_req == 1'b0, "R10 idle after reset", 32'(bus_req), 0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v = VECS[k];
            ewrite = v.wr && !v.fe;
            eword  = v.wd || v.fe;
            ea = v.fe ? {v.addr[19:1], 1'b0} : v.addr;
            eb = ea + 20'd1;
            if (eword) exp_rd = {shadow[eb[5:0]], shadow[ea[5:0]]};
            else       exp_rd = {8'h00, shadow[ea[5:0]]};
            if (ewrite) begin
                shadow[ea[5:0]] = v.wdata[7:0];
                if (eword) shadow[eb[5:0]] = v.wdata[15:8];
            end
            run_req(v, rd);
            // R1 R4 R7: cycle count
            chk(nlog == int'(v.ncyc), "R1/R4/R7 bus cycle count", nlog, 32'(v.ncyc));
            // R2 R3 R7: first cycle address and enable code
            chk(log_addr[0] == ea && log_sel[0] == v.sel0, "R2/R3/R7 first cycle",
                {log_sel[0], log_addr[0]}, {v.sel0, ea});
            chk(log_we[0] == ewrite, "R7 write strobe", 32'(log_we[0]), 32'(ewrite));
            if (v.ncyc == 2'd2) begin
                // R4 R8: second cycle at N+1, even bank only
                chk(log_addr[1] == eb && log_sel[1] == 2'b10, "R4/R8 second cycle",
                    {log_sel[1], log_addr[1]}, {2'b10, eb});
            end
            if (ewrite) begin
                if (v.ncyc == 2'd2) begin
                    chk(log_wdata[0] == {2{v.wdata[7:0]}} && log_wdata[1] == {2{v.wdata[15:8]}},
                        "R4/R6 split write lanes", {log_wdata[0], log_wdata[1]},
                        {v.wdata[7:0], v.wdata[7:0], v.wdata[15:8], v.wdata[15:8]});
                end else if (eword) begin
                    chk(log_wdata[0] == v.wdata, "R1 word write lanes", log_wdata[0], v.wdata);
                end else begin
                    chk(log_wdata[0] == {2{v.wdata[7:0]}}, "R6 byte write copy",
                        log_wdata[0], {2{v.wdata[7:0]}});
                end
                mem_ok = 1;
                for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) mem_ok = 0;
                chk(mem_ok, "R6 memory image after write", 32'(mem_ok), 1);
            end else begin
                chk(rd == exp_rd, "R1/R2/R3/R5 read result", rd, exp_rd);
            end
        end

        chk(hold_bad == 0, "R9 bus held during waits", hold_bad, 0);

        // reset in the middle of a bus cycle
        @(negedge clk);
        nlog = 0; wait_cfg = 15;
        req_write = 1'b0; req_word = 1'b1; req_fetch = 1'b0;
        req_addr = 20'h00005; req_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(bus_req == 1'b1, "R9 cycle pending under waits", 32'(bus_req), 1);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(bus_req == 1'b0 && core_done == 1'b0, "R10 reset mid cycle",
            {bus_req, core_done}, 0);
        rst_n = 1'b1;
        begin
            vec_t v2 = '{1'b0, 1'b1, 1'b0, 20'h00005, 16'h0000, 2'd2, 2'b01, 4'd0};
            run_req(v2, rd);
            chk(rd == {shadow[6], shadow[5]}, "R5 read after reset",
                rd, {shadow[6], shadow[5]});
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule